// File: doc/BRIEF.md
# Two-Thread Priority Decode Arbiter

This block decides, every enabled cycle, which of two hardware threads owns the single shared instruction decode slot. Software gives each thread a 3-bit priority (0 to 7). The arbiter turns the signed gap between the two priorities into a repeating window of slots. Inside that window the higher-priority thread owns every slot but the last one, so a wider gap gives a more unequal decode rate. The only way priority is enforced is through how often each thread is allowed to decode.

Two priority pairs are treated as special modes. A 7 paired with a 0 puts the core in single-thread operation, and the thread at 7 takes every slot. A 1 paired with a 1 puts the core in power-save operation, where a decode is granted only once in every 32 enabled cycles. If the thread that owns a slot is not ready, the slot passes to the other thread when that thread can use it. New priority values are applied only at a window boundary, so the decode ratio in force is never a blend of the old and new settings. A clock-enable input freezes the schedule and blocks all grants while it is low.

Top module: `prio_decode_arbiter`

## Requirements
- R1: `grant` is one-hot or zero (bit 0 = thread 0, bit 1 = thread 1). A thread is granted only while its ready input is high. With both ready inputs low, no grant is issued.
- R2: When both active priorities are equal and non-zero (other than the pair 1,1), the window is 2 slots. Thread 0 owns slot 0 and thread 1 owns slot 1, which gives 32 grants each over 64 enabled cycles.
- R3: When both active priorities are non-zero and differ by d, let k = min(|d|,3) and L = 2^(k+1). The higher-priority thread owns slots 0..L-2 of each L-slot window and the lower one owns slot L-1.
- R4: A thread whose active priority is 0 is never granted. With two priorities of 0, nothing is granted.
- R5: The pair (7,0) or (0,7) raises `single_thread`. The thread at 7 is granted on every enabled cycle in which it is ready.
- R6: The pair (1,1) raises `power_save`. Exactly one slot exists in each 32-cycle window, at its last position. That slot alternates between the threads, and thread 0 takes the first one after reset.
- R7: When the thread that owns a slot is not ready, or its priority is 0, the slot goes to the other thread if that thread is ready and has non-zero priority.
- R8: The first enabled cycle after reset is a load cycle with no grant. After that, the priority inputs are captured only in the last cycle of a window, and a change made mid-window leaves the rest of that window on the old ratio.
- R9: `single_thread` and `power_save` are registered. Both are low during reset and in the load cycle, they are never high together, and they change only in the first cycle of a new window.
- R10: While `en` is low, no grant is issued and the slot position is held. The schedule continues from the same position once `en` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Clock-enable; low freezes the schedule and suppresses grants |
| prio0 | input | 3 | Software priority of thread 0 |
| prio1 | input | 3 | Software priority of thread 1 |
| rdy0 | input | 1 | Thread 0 has an instruction ready to decode |
| rdy1 | input | 1 | Thread 1 has an instruction ready to decode |
| grant | output | 2 | One-hot decode grant, bit i for thread i |
| single_thread | output | 1 | Single-thread mode flag |
| power_save | output | 1 | Power-save mode flag |

## Verification
The bench goes through all 64 priority pairs from reset and counts the grants per thread over 64 enabled cycles. A design that takes the gap with the wrong sign, misses the 3-level cap, or mishandles a zero priority ends up with the wrong split. The bench changes priorities in the middle of a window: a design that applies the change at once would change the slot order early and raise a mode flag one window too soon. It also pulls `en` low in the middle of a window to catch a counter that keeps running, and drops ready on the owning thread to catch a design that wastes the slot instead of handing it over. In power-save it checks that the single slot goes to thread 0 first and then to thread 1, which exposes an alternation bit that starts at the wrong value or never toggles.

// File: rtl/pda_pkg.sv
package pda_pkg;
    typedef enum logic [2:0] {
        ST_LOAD,
        ST_EQUAL,
        ST_SKEW,
        ST_SINGLE,
        ST_PWRSAVE
    } arb_state_t;
endpackage

// File: rtl/pda_classify.sv
module pda_classify
    import pda_pkg::*;
#(
    parameter int PRIO_W   = 3,
    parameter int SKEW_CAP = 3,
    parameter int PS_LOG   = 5,
    parameter int PS_LEVEL = 1,
    parameter int CNT_W    = 5
) (
    input  logic [PRIO_W-1:0] p0_i,
    input  logic [PRIO_W-1:0] p1_i,
    output arb_state_t        mode_o,
    output logic              hi_o,
    output logic [CNT_W-1:0]  last_o
);
    localparam logic [PRIO_W-1:0] MAXP    = '1;
    localparam logic [PRIO_W-1:0] PS_P    = PRIO_W'(PS_LEVEL);
    localparam logic [CNT_W-1:0]  PS_LAST = CNT_W'((1 << PS_LOG) - 1);

    int gap;
    int lvl;

    always_comb begin
        mode_o = ST_SKEW;
        hi_o   = (p1_i > p0_i);
        last_o = '0;
        gap    = 0;
        lvl    = 0;
        if (p0_i == p1_i) begin
            hi_o = 1'b0;
            if (p0_i == PS_P) begin
                mode_o = ST_PWRSAVE;
                last_o = PS_LAST;
            end else begin
                mode_o = ST_EQUAL;
                last_o = CNT_W'(1);
            end
        end else begin
            if ((p0_i == '0 && p1_i == MAXP) || (p1_i == '0 && p0_i == MAXP))
                mode_o = ST_SINGLE;
            gap    = (p1_i > p0_i) ? (int'(p1_i) - int'(p0_i))
                                   : (int'(p0_i) - int'(p1_i));
            lvl    = (gap > SKEW_CAP) ? SKEW_CAP : gap;
            last_o = CNT_W'((1 << (lvl + 1)) - 1);
        end
    end
endmodule

// File: rtl/pda_window.sv
module pda_window #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] last_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             win_end_o
);
    assign win_end_o = en && (cnt_o == last_i);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (win_end_o)
            cnt_o <= '0;
        else if (en)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/pda_pick.sv
module pda_pick
    import pda_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  arb_state_t       state_i,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] last_i,
    input  logic             hi_i,
    input  logic             alt_i,
    input  logic [1:0]       elig_i,
    output logic [1:0]       grant_o
);
    logic slot;
    logic owner;

    always_comb begin
        slot  = 1'b0;
        owner = 1'b0;
        unique case (state_i)
            ST_LOAD: begin
                slot  = 1'b0;
                owner = 1'b0;
            end
            ST_EQUAL: begin
                slot  = 1'b1;
                owner = cnt_i[0];
            end
            ST_SKEW, ST_SINGLE: begin
                slot  = 1'b1;
                owner = (cnt_i == last_i) ? ~hi_i : hi_i;
            end
            ST_PWRSAVE: begin
                slot  = (cnt_i == last_i);
                owner = alt_i;
            end
            default: begin
                slot  = 1'b0;
                owner = 1'b0;
            end
        endcase

        grant_o = 2'b00;
        if (en && slot) begin
            if (elig_i[owner])
                grant_o[owner] = 1'b1;
            else if (elig_i[~owner])
                grant_o[~owner] = 1'b1;
        end
    end
endmodule

// File: rtl/prio_decode_arbiter.sv
module prio_decode_arbiter
    import pda_pkg::*;
#(
    parameter int PRIO_W   = 3,
    parameter int SKEW_CAP = 3,
    parameter int PS_LOG   = 5,
    parameter int PS_LEVEL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PRIO_W-1:0] prio0,
    input  logic [PRIO_W-1:0] prio1,
    input  logic              rdy0,
    input  logic              rdy1,
    output logic [1:0]        grant,
    output logic              single_thread,
    output logic              power_save
);
    localparam int CNT_W = (PS_LOG > SKEW_CAP + 1) ? PS_LOG : SKEW_CAP + 1;

    arb_state_t        state_q;
    arb_state_t        mode_n;
    logic              hi_n;
    logic              hi_q;
    logic              alt_q;
    logic [CNT_W-1:0]  last_n;
    logic [CNT_W-1:0]  last_q;
    logic [CNT_W-1:0]  cnt;
    logic              win_end;
    logic [PRIO_W-1:0] p0_q;
    logic [PRIO_W-1:0] p1_q;
    logic [1:0]        elig;

    pda_classify #(
        .PRIO_W   (PRIO_W),
        .SKEW_CAP (SKEW_CAP),
        .PS_LOG   (PS_LOG),
        .PS_LEVEL (PS_LEVEL),
        .CNT_W    (CNT_W)
    ) u_classify (
        .p0_i   (prio0),
        .p1_i   (prio1),
        .mode_o (mode_n),
        .hi_o   (hi_n),
        .last_o (last_n)
    );

    pda_window #(.CNT_W(CNT_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .last_i    (last_q),
        .cnt_o     (cnt),
        .win_end_o (win_end)
    );

    // State register: a new mode and new priorities are taken only at a window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            p0_q    <= '0;
            p1_q    <= '0;
            hi_q    <= 1'b0;
            last_q  <= '0;
            alt_q   <= 1'b0;
        end else if (win_end) begin
            state_q <= mode_n;
            p0_q    <= prio0;
            p1_q    <= prio1;
            hi_q    <= hi_n;
            last_q  <= last_n;
            if (state_q == ST_PWRSAVE)
                alt_q <= ~alt_q;
        end
    end

    assign elig[0] = rdy0 && (p0_q != '0);
    assign elig[1] = rdy1 && (p1_q != '0);

    pda_pick #(.CNT_W(CNT_W)) u_pick (
        .state_i (state_q),
        .en      (en),
        .cnt_i   (cnt),
        .last_i  (last_q),
        .hi_i    (hi_q),
        .alt_i   (alt_q),
        .elig_i  (elig),
        .grant_o (grant)
    );

    // Output process: mode flags come straight from the registered state.
    always_comb begin
        single_thread = 1'b0;
        power_save    = 1'b0;
        unique case (state_q)
            ST_SINGLE:  single_thread = 1'b1;
            ST_PWRSAVE: power_save    = 1'b1;
            ST_LOAD, ST_EQUAL, ST_SKEW: begin
                single_thread = 1'b0;
                power_save    = 1'b0;
            end
            default: begin
                single_thread = 1'b0;
                power_save    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pda_checker.sv
module pda_checker #(
    parameter int PRIO_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              rdy0,
    input logic              rdy1,
    input logic [1:0]        grant,
    input logic              single_thread,
    input logic              power_save,
    input logic [PRIO_W-1:0] act_p0,
    input logic [PRIO_W-1:0] act_p1,
    input logic              win_end
);
    localparam logic [PRIO_W-1:0] MAXP = '1;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R1
    AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] |-> rdy0) and (grant[1] |-> rdy1)); // R1
    AST_NO_GRANT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (grant == 2'b00)); // R10
    AST_ZERO_PRIO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] |-> act_p0 != '0) and (grant[1] |-> act_p1 != '0)); // R4
    AST_SINGLE_OWNS_T1: assert property (@(posedge clk) disable iff (!rst_n)
        (single_thread && en && rdy1 && act_p1 == MAXP) |-> grant == 2'b10); // R5
    AST_SINGLE_OWNS_T0: assert property (@(posedge clk) disable iff (!rst_n)
        (single_thread && en && rdy0 && act_p0 == MAXP) |-> grant == 2'b01); // R5
    AST_PS_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
        (power_save && grant != 2'b00) |=> (!power_save || grant == 2'b00)); // R6
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(single_thread && power_save)); // R9
    AST_FLAGS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ((power_save != $past(power_save)) || (single_thread != $past(single_thread)))
        |-> $past(win_end)); // R9
endmodule

bind prio_decode_arbiter pda_checker #(.PRIO_W(PRIO_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .rdy0          (rdy0),
    .rdy1          (rdy1),
    .grant         (grant),
    .single_thread (single_thread),
    .power_save    (power_save),
    .act_p0        (p0_q),
    .act_p1        (p1_q),
    .win_end       (win_end)
);

// File: tb/prio_decode_arbiter_tb.sv
module prio_decode_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [2:0] prio0 = 3'd0;
    logic [2:0] prio1 = 3'd0;
    logic       rdy0 = 1'b1;
    logic       rdy1 = 1'b1;
    logic [1:0] grant;
    logic       single_thread;
    logic       power_save;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    prio_decode_arbiter u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .prio0         (prio0),
        .prio1         (prio1),
        .rdy0          (rdy0),
        .rdy1          (rdy1),
        .grant         (grant),
        .single_thread (single_thread),
        .power_save    (power_save)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset with given priorities; leaves the bench at the negedge of the first mode cycle minus one.
    task automatic restart(input int a, input int b, input bit r0, input bit r1);
        rst_n = 1'b0;
        prio0 = 3'(a);
        prio1 = 3'(b);
        rdy0  = r0;
        rdy1  = r1;
        en    = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(grant == 2'b00 && !single_thread && !power_save, "R8 load cycle",
            {grant, single_thread, power_save}, 0);
    endtask

    // Count grants over 64 enabled cycles starting at the first mode cycle.
    task automatic count64(output int n0, output int n1, output int bad, output int at31, output int at63);
        n0 = 0; n1 = 0; bad = 0; at31 = 0; at63 = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (grant[0]) n0++;
            if (grant[1]) n1++;
            if (grant == 2'b11) bad++;
            if (i == 31) at31 = grant;
            if (i == 63) at63 = grant;
        end
    endtask

    task automatic expect_seq(input logic [1:0] exp, input string req);
        @(negedge clk);
        chk(grant == exp, req, grant, exp);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n0, n1, bad, at31, at63, e0, e1, d, k, len;
        bit est, eps;

        // Sweep of every priority pair: R2 R3 R4 R5 R6 R9 R1
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                restart(a, b, 1'b1, 1'b1);
                est = ((a == 7 && b == 0) || (a == 0 && b == 7));
                eps = (a == 1 && b == 1);
                if (a == b) begin
                    if (a == 0) begin e0 = 0; e1 = 0; end
                    else if (a == 1) begin e0 = 1; e1 = 1; end
                    else begin e0 = 32; e1 = 32; end
                end else if (a == 0 || b == 0) begin
                    e0 = (a != 0) ? 64 : 0;
                    e1 = (b != 0) ? 64 : 0;
                end else begin
                    d   = (a > b) ? a - b : b - a;
                    k   = (d > 3) ? 3 : d;
                    len = 1 << (k + 1);
                    e0  = (a > b) ? 64 - 64 / len : 64 / len;
                    e1  = 64 - e0;
                end
                @(negedge clk);
                chk(single_thread == est && power_save == eps, "R9 mode flags",
                    {single_thread, power_save}, {est, eps});
                count64(n0, n1, bad, at31, at63);
                // the first negedge was consumed for flags; count the missing slot by re-sweep logic:
                // the window is periodic, so 64 cycles from offset 1 give the same totals.
                if (a == b && a != 0 && a != 1)
                    chk(n0 == e0 && n1 == e1, "R2 equal split", n0 * 100 + n1, e0 * 100 + e1);
                else if (a == 0 || b == 0)
                    chk(n0 == e0 && n1 == e1, est ? "R5 single thread" : "R4 zero priority",
                        n0 * 100 + n1, e0 * 100 + e1);
                else if (eps)
                    chk(n0 == e0 && n1 == e1, "R6 power save count", n0 * 100 + n1, e0 * 100 + e1);
                else
                    chk(n0 == e0 && n1 == e1, "R3 skew split", n0 * 100 + n1, e0 * 100 + e1);
                chk(bad == 0, "R1 one-hot", bad, 0);
                if (eps) begin
                    // sampling started at slot 1: slot 31 is sample 30, next slot 31 is sample 62
                    chk(at31 == 0 && at63 == 0, "R6 no grant off-slot", at31 * 10 + at63, 0);
                end
            end
        end

        // R6: power-save alternation, thread 0 first
        restart(1, 1, 1'b1, 1'b1);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (i == 31) chk(grant == 2'b01, "R6 first slot to thread 0", grant, 1);
            else if (i == 63) chk(grant == 2'b10, "R6 second slot to thread 1", grant, 2);
        end

        // R7: fallback when owner not ready
        restart(3, 3, 1'b0, 1'b1);
        count64(n0, n1, bad, at31, at63);
        chk(n0 == 0 && n1 == 64, "R7 equal fallback", n0 * 100 + n1, 64);
        restart(6, 2, 1'b0, 1'b1);
        count64(n0, n1, bad, at31, at63);
        chk(n0 == 0 && n1 == 64, "R7 skew fallback", n0 * 100 + n1, 64);
        restart(4, 6, 1'b1, 1'b0);
        count64(n0, n1, bad, at31, at63);
        chk(n0 == 64 && n1 == 0, "R7 fallback to lower", n0 * 100 + n1, 6400);
        restart(5, 5, 1'b0, 1'b0);
        count64(n0, n1, bad, at31, at63);
        chk(n0 == 0 && n1 == 0, "R1 none ready", n0 * 100 + n1, 0);
        restart(7, 0, 1'b0, 1'b1);
        count64(n0, n1, bad, at31, at63);
        chk(n0 == 0 && n1 == 0, "R4 zero priority not a fallback", n0 * 100 + n1, 0);

        // R8: mid-window change keeps the old ratio; R9 flag timing
        restart(5, 2, 1'b1, 1'b1);
        for (int i = 0; i < 16; i++) begin
            expect_seq((i < 15) ? 2'b01 : 2'b10, "R8 old ratio kept");
            if (i == 4) begin
                prio0 = 3'd2;
                prio1 = 3'd2;
            end
        end
        expect_seq(2'b01, "R8 new ratio slot 0");
        expect_seq(2'b10, "R8 new ratio slot 1");
        expect_seq(2'b01, "R8 new ratio slot 0 again");
        prio0 = 3'd1;
        prio1 = 3'd1;
        expect_seq(2'b10, "R8 change waits for boundary");
        chk(power_save == 1'b0, "R9 flag not early", power_save, 0);
        @(negedge clk);
        chk(power_save == 1'b1 && grant == 2'b00, "R9 flag with new window",
            {power_save, grant}, 4);

        // R10: enable low freezes the schedule
        restart(4, 2, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) expect_seq(2'b01, "R10 before pause");
        en = 1'b0;
        for (int i = 0; i < 5; i++) expect_seq(2'b00, "R10 paused");
        en = 1'b1;
        for (int i = 0; i < 4; i++) expect_seq(2'b01, "R10 resumed");
        expect_seq(2'b10, "R10 lower slot at held position");
        expect_seq(2'b01, "R3 next window");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule